// File: doc/BRIEF.md
# Indirect-Access Network Controller Register Bank

This block is the control and status register bank of a bus-mastering network controller. The host reaches it through two 16-bit ports. A write to the select port picks one of four registers. Writes and reads on the data port then go to the register that is selected. Register 0 is the command and status word. Registers 1 and 2 hold the low and high parts of the address of the initialization block in memory. Register 3 holds three bus-mode bits.

The MAC and DMA logic report events as single-cycle pulses on `mac_evt`. These pulses set sticky status bits in register 0. The host clears them by writing 1 to them. An error summary bit and an interrupt summary bit are derived from the status bits, and `irq` is raised when interrupts are enabled. One-shot commands in register 0 start an initialization, start the transmitter and receiver, request a transmit-ring poll, or stop the controller. The rest of the controller sees the command results as level and pulse outputs.

Top module: `nic_csr_bank`

## Requirements
- R1: A write on the select port (`host_addr_we`) picks register `host_wdata[1:0]` (0 command/status, 1 base low, 2 base high, 3 bus mode). Reset selects register 0. A data-port write in the same cycle as a select write goes to the register selected before that cycle. `host_rdata` is registered: it shows the selected register as it stood one clock earlier.
- R2: Register 0 layout: bit 15 error summary, bits 14..8 status, bit 7 interrupt summary, bit 6 interrupt enable, bit 5 receiver on, bit 4 transmitter on, bit 3 transmit demand, bit 2 stop, bit 1 start, bit 0 init. Bit 15 reads 1 exactly when any of bits 14..11 is set.
- R3: `mac_evt[k]` sets register 0 bit 8+k (bit 6 babble, 5 heartbeat fail, 4 missed frame, 3 memory error, 2 receive done, 1 transmit done, 0 init done). Events are ignored while stop is set. An event wins over a clear of the same bit in the same cycle.
- R4: Writing 1 to a status bit (bits 14..8) clears it. Writing 0 leaves it unchanged.
- R5: Bit 7 reads 1 exactly when any status bit is set. `irq` is high exactly when bit 7 and bit 6 are both set.
- R6: Bit 6 (interrupt enable) is written by any register 0 write that does not set stop, and it reads back as written.
- R7: A register 0 write with bit 2 set sets stop and clears receiver on, transmitter on, interrupt enable and all status bits. All other bits of that write are ignored. `stopped` mirrors the stop bit.
- R8: A register 0 write with bit 1 set (bit 2 clear) clears stop and sets receiver on and transmitter on, which drive `rx_en` and `tx_en`.
- R9: A register 0 write with bit 0 set (bit 2 clear) clears stop and raises `init_req` for exactly the next cycle. A write with bit 3 set (bit 2 clear) raises `tx_demand` for the next cycle only if the transmitter was already on. Bits 3, 1 and 0 always read 0.
- R10: Registers 1 (16 bits), 2 (low 8 bits) and 3 (low 3 bits) change only on writes made while stop is set. Their unused bits read 0. `init_addr` is {register 2, register 1}. `bus_mode` is register 3: bit 2 byte swap, bit 1 address-latch polarity, bit 0 byte control.
- R11: After reset, register 0 reads 0x0004, registers 1 to 3 read 0, `irq`, `rx_en`, `tx_en`, `init_req` and `tx_demand` are low and `stopped` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr_we | input | 1 | Write strobe of the register-select port |
| host_data_we | input | 1 | Write strobe of the data port |
| host_wdata | input | 16 | Write data shared by both ports |
| host_rdata | output | 16 | Registered read data of the selected register |
| mac_evt | input | 7 | Single-cycle event pulses from MAC and DMA logic |
| irq | output | 1 | Interrupt request |
| init_req | output | 1 | One-cycle request to fetch the initialization block |
| tx_demand | output | 1 | One-cycle request for an immediate transmit-ring poll |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| stopped | output | 1 | Controller halted |
| init_addr | output | 24 | Initialization block address |
| bus_mode | output | 3 | Bus-mode control bits |

## Verification
A wrong status or enable flop shows at `irq` in the same cycle it goes wrong, and in `host_rdata` two clocks after the host selects register 0. A wrong select register shows as data from another register on the very next read. A lock that lets configuration writes through while running shows at `init_addr` or `bus_mode` one clock after the write. A stuck or doubled command pulse shows at `init_req` or `tx_demand` in the cycle after the write.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int CSR_W  = 16;
  localparam int EVT_N  = 7;
  localparam int MODE_W = 3;
  localparam int ERR_N  = 4;

  // Register 0 bit positions
  localparam int B_ERR    = 15;
  localparam int B_EVT_LO = 8;
  localparam int B_INTR   = 7;
  localparam int B_INEA   = 6;
  localparam int B_RXON   = 5;
  localparam int B_TXON   = 4;
  localparam int B_TDMD   = 3;
  localparam int B_STOP   = 2;
  localparam int B_STRT   = 1;
  localparam int B_INIT   = 0;

  typedef enum logic [1:0] {
    SEL_CMD     = 2'd0,
    SEL_BASE_LO = 2'd1,
    SEL_BASE_HI = 2'd2,
    SEL_MODE    = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/nic_csr_status.sv
module nic_csr_status #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic         w1c_we,
  input  logic [N-1:0] w1c_mask,
  input  logic [N-1:0] evt,
  input  logic         evt_en,
  output logic [N-1:0] status_q
);
  logic [N-1:0] keep;
  logic [N-1:0] seen;

  always_comb begin
    keep = w1c_we ? (status_q & ~w1c_mask) : status_q;
    seen = evt & {N{evt_en}};
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) status_q <= '0;
    else                status_q <= keep | seen;
  end
endmodule

// File: rtl/nic_csr_cmd.sv
module nic_csr_cmd
  import nic_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [CSR_W-1:0] wdata,
  output logic             stop_hit,
  output logic             stop_q,
  output logic             run_q,
  output logic             inea_q,
  output logic             init_pulse_q,
  output logic             tdmd_pulse_q
);
  logic go;
  logic unused_cmd_bits;

  assign stop_hit = cmd_we & wdata[B_STOP];
  assign go       = cmd_we & ~wdata[B_STOP];
  assign unused_cmd_bits = ^{wdata[B_ERR:B_EVT_LO], wdata[B_INTR], wdata[B_RXON], wdata[B_TXON]};

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q       <= 1'b1;
      run_q        <= 1'b0;
      inea_q       <= 1'b0;
      init_pulse_q <= 1'b0;
      tdmd_pulse_q <= 1'b0;
    end else begin
      init_pulse_q <= go & wdata[B_INIT];
      tdmd_pulse_q <= go & wdata[B_TDMD] & run_q;
      if (stop_hit) begin
        stop_q <= 1'b1;
        run_q  <= 1'b0;
        inea_q <= 1'b0;
      end else if (go) begin
        inea_q <= wdata[B_INEA];
        if (wdata[B_STRT]) begin
          stop_q <= 1'b0;
          run_q  <= 1'b1;
        end
        if (wdata[B_INIT]) stop_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nic_csr_cfg.sv
module nic_csr_cfg
  import nic_csr_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_we,
  input  logic [1:0]        sel_wdata,
  input  logic              data_we,
  input  logic              unlocked,
  input  logic [CSR_W-1:0]  wdata,
  output csr_sel_e          sel_q,
  output logic [CSR_W-1:0]  base_lo_q,
  output logic [HI_W-1:0]   base_hi_q,
  output logic [MODE_W-1:0] mode_q
);
  logic wr_ok;
  assign wr_ok = data_we & unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= SEL_CMD;
      base_lo_q <= '0;
      base_hi_q <= '0;
      mode_q    <= '0;
    end else begin
      if (sel_we) sel_q <= csr_sel_e'(sel_wdata);
      if (wr_ok && sel_q == SEL_BASE_LO) base_lo_q <= wdata;
      if (wr_ok && sel_q == SEL_BASE_HI) base_hi_q <= wdata[HI_W-1:0];
      if (wr_ok && sel_q == SEL_MODE)    mode_q    <= wdata[MODE_W-1:0];
    end
  end
endmodule

// File: rtl/nic_csr_bank.sv
module nic_csr_bank
  import nic_csr_pkg::*;
#(
  parameter int HI_W = 8,
  localparam int ADDR_W = CSR_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_addr_we,
  input  logic              host_data_we,
  input  logic [CSR_W-1:0]  host_wdata,
  output logic [CSR_W-1:0]  host_rdata,
  input  logic [EVT_N-1:0]  mac_evt,
  output logic              irq,
  output logic              init_req,
  output logic              tx_demand,
  output logic              rx_en,
  output logic              tx_en,
  output logic              stopped,
  output logic [ADDR_W-1:0] init_addr,
  output logic [MODE_W-1:0] bus_mode
);
  csr_sel_e          sel_q;
  logic [CSR_W-1:0]  base_lo_q;
  logic [HI_W-1:0]   base_hi_q;
  logic [MODE_W-1:0] mode_q;
  logic [EVT_N-1:0]  status_q;
  logic              stop_hit, stop_q, run_q, inea_q, init_pulse_q, tdmd_pulse_q;
  logic              cmd_we, err_sum, intr_sum;
  logic [CSR_W-1:0]  rd_mux;

  assign cmd_we = host_data_we & (sel_q == SEL_CMD);

  nic_csr_cfg #(.HI_W(HI_W)) u_cfg (
    .clk(clk), .rst(rst),
    .sel_we(host_addr_we), .sel_wdata(host_wdata[1:0]),
    .data_we(host_data_we), .unlocked(stop_q), .wdata(host_wdata),
    .sel_q(sel_q), .base_lo_q(base_lo_q), .base_hi_q(base_hi_q), .mode_q(mode_q)
  );

  nic_csr_cmd u_cmd (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .wdata(host_wdata),
    .stop_hit(stop_hit), .stop_q(stop_q), .run_q(run_q), .inea_q(inea_q),
    .init_pulse_q(init_pulse_q), .tdmd_pulse_q(tdmd_pulse_q)
  );

  nic_csr_status #(.N(EVT_N)) u_status (
    .clk(clk), .rst(rst), .clr_all(stop_hit),
    .w1c_we(cmd_we), .w1c_mask(host_wdata[B_ERR-1:B_EVT_LO]),
    .evt(mac_evt), .evt_en(~stop_q), .status_q(status_q)
  );

  assign err_sum  = |status_q[EVT_N-1:EVT_N-ERR_N];
  assign intr_sum = |status_q;

  always_comb begin
    rd_mux = '0;
    unique case (sel_q)
      SEL_CMD: begin
        rd_mux[B_ERR]              = err_sum;
        rd_mux[B_ERR-1:B_EVT_LO]   = status_q;
        rd_mux[B_INTR]             = intr_sum;
        rd_mux[B_INEA]             = inea_q;
        rd_mux[B_RXON]             = run_q;
        rd_mux[B_TXON]             = run_q;
        rd_mux[B_STOP]             = stop_q;
      end
      SEL_BASE_LO: rd_mux = base_lo_q;
      SEL_BASE_HI: rd_mux[HI_W-1:0] = base_hi_q;
      SEL_MODE:    rd_mux[MODE_W-1:0] = mode_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_mux;
  end

  assign irq       = intr_sum & inea_q;
  assign init_req  = init_pulse_q;
  assign tx_demand = tdmd_pulse_q;
  assign rx_en     = run_q;
  assign tx_en     = run_q;
  assign stopped   = stop_q;
  assign init_addr = {base_hi_q, base_lo_q};
  assign bus_mode  = mode_q;
endmodule

// File: rtl/nic_csr_chk.sv
module nic_csr_chk #(
  parameter int HI_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             host_data_we,
  input logic             wr_stop,
  input logic             wr_init,
  input logic [1:0]       sel_q,
  input logic             stopped,
  input logic             rx_en,
  input logic             tx_en,
  input logic             irq,
  input logic             init_req,
  input logic             tx_demand,
  input logic [6:0]       status_q,
  input logic             inea_q,
  input logic [16+HI_W-1:0] init_addr
);
  a_r11_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stopped && !rx_en && !irq && sel_q == 2'd0));

  a_r7_stop_clears: assert property (@(posedge clk) disable iff (rst)
    (host_data_we && sel_q == 2'd0 && wr_stop) |=> (stopped && !rx_en && !tx_en && status_q == '0 && !inea_q));

  a_r3_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
    stopped |-> (status_q == '0 && !irq));

  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> inea_q);

  a_r9_init_from_write: assert property (@(posedge clk) disable iff (rst)
    init_req |-> $past(host_data_we && sel_q == 2'd0 && wr_init && !wr_stop));

  a_r9_tdmd_needs_tx: assert property (@(posedge clk) disable iff (rst)
    tx_demand |-> $past(tx_en));

  a_r8_run_not_stopped: assert property (@(posedge clk) disable iff (rst)
    rx_en |-> !stopped);

  a_r10_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    !$stable(init_addr) |-> $past(stopped));
endmodule

bind nic_csr_bank nic_csr_chk #(.HI_W(HI_W)) u_chk (
  .clk(clk), .rst(rst), .host_data_we(host_data_we),
  .wr_stop(host_wdata[2]), .wr_init(host_wdata[0]), .sel_q(sel_q),
  .stopped(stopped), .rx_en(rx_en), .tx_en(tx_en), .irq(irq),
  .init_req(init_req), .tx_demand(tx_demand), .status_q(status_q),
  .inea_q(inea_q), .init_addr(init_addr)
);

// File: tb/tb_nic_csr_bank.sv
module tb_nic_csr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_addr_we = 1'b0;
  logic        host_data_we = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [6:0]  mac_evt = '0;
  logic        irq, init_req, tx_demand, rx_en, tx_en, stopped;
  logic [23:0] init_addr;
  logic [2:0]  bus_mode;

  int checks = 0;
  int failures = 0;
  logic [15:0] rv;

  always #4 clk = ~clk;

  nic_csr_bank #(.HI_W(8)) dut (
    .clk(clk), .rst(rst), .host_addr_we(host_addr_we), .host_data_we(host_data_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mac_evt(mac_evt), .irq(irq),
    .init_req(init_req), .tx_demand(tx_demand), .rx_en(rx_en), .tx_en(tx_en),
    .stopped(stopped), .init_addr(init_addr), .bus_mode(bus_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sel(input int n);
    host_addr_we = 1'b1; host_wdata = 16'(n);
    @(negedge clk);
    host_addr_we = 1'b0; host_wdata = '0;
  endtask

  task automatic wr(input logic [15:0] v);
    host_data_we = 1'b1; host_wdata = v;
    @(negedge clk);
    host_data_we = 1'b0; host_wdata = '0;
  endtask

  task automatic wr_reg(input int n, input logic [15:0] v);
    sel(n); wr(v);
  endtask

  task automatic rd(input int n, output logic [15:0] v);
    sel(n);
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic pulse_evt(input int k);
    mac_evt = 7'(1 << k);
    @(negedge clk);
    mac_evt = '0;
  endtask

  initial begin
    repeat (1000) @(negedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 stopped", stopped, 1);
    chk("R11 outs", {irq, rx_en, tx_en, init_req, tx_demand}, 0);
    chk("R11 init_addr", init_addr, 0);
    rd(0, rv); chk("R11 csr0", rv, 16'h0004);
    rd(3, rv); chk("R11 csr3", rv, 0);

    // R10 sweep of bus mode and base registers while stopped
    for (int m = 0; m < 8; m++) begin
      wr_reg(3, 16'hFFF8 | 16'(m));
      chk("R10 bus_mode", bus_mode, m);
      rd(3, rv); chk("R10 csr3 read", rv, m);
    end
    for (int b = 0; b < 16; b++) begin
      wr_reg(1, 16'(1 << b));
      rd(1, rv); chk("R10 csr1 read", rv, 1 << b);
    end
    wr_reg(2, 16'hA5C3);
    rd(2, rv); chk("R10 csr2 read", rv, 16'h00C3);
    chk("R10 init_addr", init_addr, 24'hC38000);

    // R1 select and data write in same cycle: data goes to old selection (2)
    host_addr_we = 1'b1; host_data_we = 1'b1; host_wdata = 16'h0001;
    @(negedge clk);
    host_addr_we = 1'b0; host_data_we = 1'b0; host_wdata = '0;
    chk("R1 same-cycle write to old sel", init_addr[23:16], 8'h01);
    chk("R1 base low kept", init_addr[15:0], 16'h8000);
    @(negedge clk);
    chk("R1 rdata shows new sel", host_rdata, 16'h8000);

    // R9 init pulse
    wr_reg(0, 16'h0001);
    chk("R9 init_req pulse", init_req, 1);
    chk("R9 stop cleared by init", stopped, 0);
    @(negedge clk);
    chk("R9 init_req one cycle", init_req, 0);
    rd(0, rv); chk("R9 csr0 after init", rv, 16'h0000);

    // R10 lock while running
    wr_reg(1, 16'h1234);
    wr_reg(3, 16'h0005);
    rd(1, rv); chk("R10 csr1 locked", rv, 16'h8000);
    chk("R10 bus_mode locked", bus_mode, 3'd7);

    // R8 start
    wr_reg(0, 16'h0002);
    chk("R8 rx_en", rx_en, 1);
    chk("R8 tx_en", tx_en, 1);
    rd(0, rv); chk("R8 csr0 running", rv, 16'h0030);

    // R3 R4 R5 R6 R2 sweep each event
    for (int k = 0; k < 7; k++) begin
      logic [15:0] bit_k, exp_base;
      bit_k = 16'(1 << (8 + k));
      exp_base = 16'h0030 | bit_k | 16'h0080 | ((k >= 3) ? 16'h8000 : 16'h0);
      pulse_evt(k);
      chk("R5 irq disabled", irq, 0);
      rd(0, rv); chk("R3 R2 event sets status", rv, exp_base);
      wr(16'h0040);
      chk("R5 irq enabled", irq, 1);
      rd(0, rv); chk("R4 R6 write 0 keeps status", rv, exp_base | 16'h0040);
      wr(bit_k | 16'h0040);
      chk("R5 irq after clear", irq, 0);
      rd(0, rv); chk("R4 write 1 clears", rv, 16'h0070);
      wr(16'h0000);
      rd(0, rv); chk("R6 enable cleared", rv, 16'h0030);
    end

    // R3 event wins over same-cycle clear
    sel(0);
    host_data_we = 1'b1; host_wdata = 16'h0400; mac_evt = 7'b0000100;
    @(negedge clk);
    host_data_we = 1'b0; host_wdata = '0; mac_evt = '0;
    rd(0, rv); chk("R3 event beats clear", rv, 16'h04B0);

    // R9 transmit demand while running
    wr_reg(0, 16'h0008);
    chk("R9 tx_demand pulse", tx_demand, 1);
    @(negedge clk);
    chk("R9 tx_demand one cycle", tx_demand, 0);

    // R7 stop with other bits set
    wr_reg(0, 16'h0047);
    chk("R7 stopped", stopped, 1);
    chk("R7 run off", {rx_en, tx_en, init_req}, 0);
    rd(0, rv); chk("R7 csr0 after stop", rv, 16'h0004);

    // R9 demand ignored while stopped; R3 events ignored while stopped
    wr_reg(0, 16'h0008);
    chk("R9 no demand when stopped", tx_demand, 0);
    for (int k = 0; k < 7; k++) pulse_evt(k);
    rd(0, rv); chk("R3 events ignored when stopped", rv, 16'h0004);
    chk("R3 no irq when stopped", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule